// File: doc/BRIEF.md
# Clock-Crossing Stream Endpoint

This block sits between one compute module and a chain of circuit-switched network nodes. The module runs on its own clock and the network runs on a second, unrelated clock. Every transmit lane opens a dedicated channel to a destination, streams fixed-width words through it and then closes it. Every receive lane buffers words that arrive from the network and delivers them to the module. Both directions cross between the two clocks through asynchronous FIFOs whose pointers are passed in Gray code.

On a transmit lane, the module raises a level request with a destination code. The network side answers with a one-cycle grant or deny. After a deny, the module either lowers the request to give up, or keeps it high, in which case the block asks again on its own. Once the channel is open, buffered words leave one per network cycle unless the far end signals full. Lowering the request closes the channel, but only after every buffered word has left. On a receive lane, the block warns the network that it is full while a small margin of entries is still free. This margin absorbs words that are already in flight.

The number of transmit lanes and receive lanes is set by parameters, and the lanes are fully independent.

Top module: `strm_ep`

## Requirements
- R1: After reset, net_req, net_out_valid, net_in_full and rx_valid are all low, tx_ready is high on every lane, and tx_status reads 0 (idle) on every lane.
- R2: Raising tx_req makes net_req rise, with net_dest equal to tx_dest. A grant sets tx_status to 1. If tx_req is withdrawn before any answer, net_req falls and tx_status reads 0.
- R3: A deny drops net_req in the next network cycle and sets tx_status to 2. If tx_req is still high, net_req rises again one cycle later. If tx_req has been lowered, net_req stays low.
- R4: Words are sent only while net_req is high and after a grant. They leave in the order they were accepted. When words are already buffered, the first one is presented in the network cycle after the grant.
- R5: No word is presented in a network cycle in which net_out_full is high. Sending resumes once net_out_full is low.
- R6: After tx_req falls on an open channel, net_req stays high until every buffered word has been sent, and then falls.
- R7: Words accepted on net_in_valid reach rx_data in the same order, each one handed over when rx_valid and rx_ready are both high.
- R8: net_in_full is high while the free receive entries number SLACK (default 2) or fewer. With no reads, exactly DEPTH minus SLACK words are accepted before it rises. It falls again once the module drains the buffer.
- R9: tx_ready goes low once a lane's transmit buffer holds DEPTH (default 8) words that have not been sent.
- R10: Request state, status, transmit data and receive fill level of one lane do not affect any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Module clock |
| mrst | input | 1 | Synchronous active-high reset, module domain |
| nclk | input | 1 | Network clock |
| nrst | input | 1 | Synchronous active-high reset, network domain |
| tx_req | input | TX_PORTS | Level channel request per transmit lane |
| tx_dest | input | TX_PORTS*DEST_W | Destination code per lane, held stable while requesting |
| tx_valid | input | TX_PORTS | Word offered by the module |
| tx_data | input | TX_PORTS*W | Transmit word |
| tx_ready | output | TX_PORTS | Transmit buffer has room |
| tx_status | output | TX_PORTS*2 | Outcome of the last request: 0 idle, 1 grant, 2 deny |
| rx_valid | output | RX_PORTS | Received word available |
| rx_data | output | RX_PORTS*W | Received word |
| rx_ready | input | RX_PORTS | Module takes the word |
| net_req | output | TX_PORTS | Channel request toward the network |
| net_dest | output | TX_PORTS*DEST_W | Destination captured at request start |
| net_grant | input | TX_PORTS | One-cycle grant |
| net_deny | input | TX_PORTS | One-cycle deny |
| net_out_valid | output | TX_PORTS | Word presented to the network |
| net_out_data | output | TX_PORTS*W | Outgoing word |
| net_out_full | input | TX_PORTS | Far end cannot take words |
| net_in_valid | input | RX_PORTS | Word arriving from the network |
| net_in_data | input | RX_PORTS*W | Arriving word |
| net_in_full | output | RX_PORTS | Receive buffer near full |

## Verification
Results inside the network domain are sampled at an exact cycle. A deny drops net_req at the next network edge and the retry shows one edge later. A grant exposes the first buffered word one edge after it is sampled. A raised net_out_full blocks the word at the same edge, because the bench changes that input just after a rising edge and reads outputs on the falling edge. Results that cross between clocks, such as request start, status, drain-driven release and the full flag clearing, take two synchroniser stages and a little logic. The bench therefore polls them within fixed windows of 10 to 30 cycles, which are much longer than that latency. Receive fill is driven edge by edge, so the accepted count before the full flag rises is exact.

// File: rtl/strm_ep_pkg.sv
package strm_ep_pkg;

    localparam int GRAY_MAX = 16;

    typedef enum logic [1:0] {
        LNK_IDLE  = 2'd0,
        LNK_GRANT = 2'd1,
        LNK_DENY  = 2'd2
    } link_status_e;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_ASK,
        TS_REFUSED,
        TS_OPEN,
        TS_DRAIN
    } tx_state_e;

    function automatic logic [GRAY_MAX-1:0] to_gray(input logic [GRAY_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_MAX-1:0] from_gray(input logic [GRAY_MAX-1:0] g);
        logic [GRAY_MAX-1:0] b;
        b[GRAY_MAX-1] = g[GRAY_MAX-1];
        for (int i = GRAY_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/strm_ep_sync.sv
module strm_ep_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/strm_ep_afifo.sv
module strm_ep_afifo
    import strm_ep_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 3
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [AW:0]   wr_free,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          rd_en,
    output logic          rd_empty,
    output logic [W-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_w, wgray_r, rbin_w, count;
    logic          do_wr, do_rd;

    strm_ep_sync #(.WIDTH(PW)) u_rsync (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w));
    strm_ep_sync #(.WIDTH(PW)) u_wsync (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r));

    // write side
    assign rbin_w  = PW'(from_gray(GRAY_MAX'(rgray_w)));
    assign count   = wbin - rbin_w;
    assign wr_free = PW'(DEPTH) - count;
    assign do_wr   = wr_en && (wr_free != '0);

    always_ff @(posedge wclk) begin
        if (do_wr) mem[wbin[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (do_wr) begin
            wbin  <= wbin + 1'b1;
            wgray <= PW'(to_gray(GRAY_MAX'(wbin + 1'b1)));
        end
    end

    // read side
    assign rd_empty = (rgray == wgray_r);
    assign rd_data  = mem[rbin[AW-1:0]];
    assign do_rd    = rd_en && !rd_empty;

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (do_rd) begin
            rbin  <= rbin + 1'b1;
            rgray <= PW'(to_gray(GRAY_MAX'(rbin + 1'b1)));
        end
    end

    // R7: a pointer crossing clocks moves by one Gray step at most
    a_r7_wptr_gray_step: assert property (@(posedge wclk) disable iff (wrst)
        $countones(wgray ^ $past(wgray)) <= 1);
    a_r7_rptr_gray_step: assert property (@(posedge rclk) disable iff (rrst)
        $countones(rgray ^ $past(rgray)) <= 1);
    // R9: occupancy seen by the writer never exceeds the depth
    a_r9_count_bound: assert property (@(posedge wclk) disable iff (wrst)
        count <= PW'(DEPTH));
endmodule

// File: rtl/strm_ep_tx_lane.sv
module strm_ep_tx_lane
    import strm_ep_pkg::*;
#(
    parameter int W      = 32,
    parameter int DEST_W = 4,
    parameter int AW     = 3
) (
    input  logic              mclk,
    input  logic              mrst,
    input  logic              nclk,
    input  logic              nrst,
    input  logic              tx_req,
    input  logic [DEST_W-1:0] tx_dest,
    input  logic              tx_valid,
    input  logic [W-1:0]      tx_data,
    output logic              tx_ready,
    output logic [1:0]        tx_status,
    output logic              net_req,
    output logic [DEST_W-1:0] net_dest,
    input  logic              net_grant,
    input  logic              net_deny,
    output logic              net_out_valid,
    output logic [W-1:0]      net_out_data,
    input  logic              net_out_full
);
    tx_state_e    st;
    link_status_e stat_n;
    logic         req_s, rd_empty, chan_open;
    logic [AW:0]  wr_free;
    logic [1:0]   stat_s, stat_prev;

    strm_ep_sync #(.WIDTH(1)) u_req_sync (.clk(nclk), .rst(nrst), .d(tx_req), .q(req_s));

    strm_ep_afifo #(.W(W), .AW(AW)) u_fifo (
        .wclk(mclk), .wrst(mrst), .wr_en(tx_valid), .wr_data(tx_data), .wr_free(wr_free),
        .rclk(nclk), .rrst(nrst), .rd_en(net_out_valid), .rd_empty(rd_empty),
        .rd_data(net_out_data)
    );

    assign tx_ready      = (wr_free != '0);
    assign chan_open     = (st == TS_OPEN) || (st == TS_DRAIN);
    assign net_req       = (st == TS_ASK) || chan_open;
    assign net_out_valid = chan_open && !rd_empty && !net_out_full;

    always_ff @(posedge nclk) begin
        if (nrst) begin
            st       <= TS_IDLE;
            stat_n   <= LNK_IDLE;
            net_dest <= '0;
        end else begin
            case (st)
                TS_IDLE: if (req_s) begin
                    st       <= TS_ASK;
                    net_dest <= tx_dest;
                end
                TS_ASK: begin
                    if (!req_s) begin
                        st     <= TS_IDLE;
                        stat_n <= LNK_IDLE;
                    end else if (net_grant) begin
                        st     <= TS_OPEN;
                        stat_n <= LNK_GRANT;
                    end else if (net_deny) begin
                        st     <= TS_REFUSED;
                        stat_n <= LNK_DENY;
                    end
                end
                TS_REFUSED: st <= req_s ? TS_ASK : TS_IDLE;
                TS_OPEN:    if (!req_s) st <= TS_DRAIN;
                TS_DRAIN:   if (rd_empty) st <= TS_IDLE;
                default:    st <= TS_IDLE;
            endcase
        end
    end

    // status back to the module clock, taken only once two samples agree
    strm_ep_sync #(.WIDTH(2)) u_stat_sync (.clk(mclk), .rst(mrst), .d(stat_n), .q(stat_s));

    always_ff @(posedge mclk) begin
        if (mrst) begin
            stat_prev <= '0;
            tx_status <= '0;
        end else begin
            stat_prev <= stat_s;
            if (stat_s == stat_prev) tx_status <= stat_s;
        end
    end

    a_r4_send_on_channel: assert property (@(posedge nclk) disable iff (nrst)
        net_out_valid |-> net_req);
    a_r5_halt_on_full: assert property (@(posedge nclk) disable iff (nrst)
        net_out_full |-> !net_out_valid);
    a_r3_deny_drops_req: assert property (@(posedge nclk) disable iff (nrst)
        (st == TS_ASK && req_s && net_deny && !net_grant) |=> !net_req);
    a_r6_release_after_drain: assert property (@(posedge nclk) disable iff (nrst)
        ($fell(net_req) && $past(st == TS_DRAIN)) |-> $past(rd_empty));
endmodule

// File: rtl/strm_ep_rx_lane.sv
module strm_ep_rx_lane #(
    parameter int W     = 32,
    parameter int AW    = 3,
    parameter int SLACK = 2
) (
    input  logic         mclk,
    input  logic         mrst,
    input  logic         nclk,
    input  logic         nrst,
    output logic         rx_valid,
    output logic [W-1:0] rx_data,
    input  logic         rx_ready,
    input  logic         net_in_valid,
    input  logic [W-1:0] net_in_data,
    output logic         net_in_full
);
    logic        rd_empty;
    logic [AW:0] wr_free;

    strm_ep_afifo #(.W(W), .AW(AW)) u_fifo (
        .wclk(nclk), .wrst(nrst), .wr_en(net_in_valid), .wr_data(net_in_data), .wr_free(wr_free),
        .rclk(mclk), .rrst(mrst), .rd_en(rx_ready), .rd_empty(rd_empty), .rd_data(rx_data)
    );

    assign rx_valid    = !rd_empty;
    assign net_in_full = (wr_free <= (AW+1)'(SLACK));

    // R8: a sender that honours the early full flag never meets a full buffer
    a_r8_write_has_room: assert property (@(posedge nclk) disable iff (nrst)
        net_in_valid |-> (wr_free != '0));
endmodule

// File: rtl/strm_ep.sv
module strm_ep #(
    parameter int W        = 32,
    parameter int DEST_W   = 4,
    parameter int FIFO_AW  = 3,
    parameter int SLACK    = 2,
    parameter int TX_PORTS = 2,
    parameter int RX_PORTS = 2
) (
    input  logic                             mclk,
    input  logic                             mrst,
    input  logic                             nclk,
    input  logic                             nrst,
    input  logic [TX_PORTS-1:0]              tx_req,
    input  logic [TX_PORTS-1:0][DEST_W-1:0]  tx_dest,
    input  logic [TX_PORTS-1:0]              tx_valid,
    input  logic [TX_PORTS-1:0][W-1:0]       tx_data,
    output logic [TX_PORTS-1:0]              tx_ready,
    output logic [TX_PORTS-1:0][1:0]         tx_status,
    output logic [RX_PORTS-1:0]              rx_valid,
    output logic [RX_PORTS-1:0][W-1:0]       rx_data,
    input  logic [RX_PORTS-1:0]              rx_ready,
    output logic [TX_PORTS-1:0]              net_req,
    output logic [TX_PORTS-1:0][DEST_W-1:0]  net_dest,
    input  logic [TX_PORTS-1:0]              net_grant,
    input  logic [TX_PORTS-1:0]              net_deny,
    output logic [TX_PORTS-1:0]              net_out_valid,
    output logic [TX_PORTS-1:0][W-1:0]       net_out_data,
    input  logic [TX_PORTS-1:0]              net_out_full,
    input  logic [RX_PORTS-1:0]              net_in_valid,
    input  logic [RX_PORTS-1:0][W-1:0]       net_in_data,
    output logic [RX_PORTS-1:0]              net_in_full
);
    for (genvar t = 0; t < TX_PORTS; t++) begin : g_tx
        strm_ep_tx_lane #(.W(W), .DEST_W(DEST_W), .AW(FIFO_AW)) u_tx (
            .mclk(mclk), .mrst(mrst), .nclk(nclk), .nrst(nrst),
            .tx_req(tx_req[t]), .tx_dest(tx_dest[t]), .tx_valid(tx_valid[t]),
            .tx_data(tx_data[t]), .tx_ready(tx_ready[t]), .tx_status(tx_status[t]),
            .net_req(net_req[t]), .net_dest(net_dest[t]), .net_grant(net_grant[t]),
            .net_deny(net_deny[t]), .net_out_valid(net_out_valid[t]),
            .net_out_data(net_out_data[t]), .net_out_full(net_out_full[t])
        );
    end

    for (genvar r = 0; r < RX_PORTS; r++) begin : g_rx
        strm_ep_rx_lane #(.W(W), .AW(FIFO_AW), .SLACK(SLACK)) u_rx (
            .mclk(mclk), .mrst(mrst), .nclk(nclk), .nrst(nrst),
            .rx_valid(rx_valid[r]), .rx_data(rx_data[r]), .rx_ready(rx_ready[r]),
            .net_in_valid(net_in_valid[r]), .net_in_data(net_in_data[r]),
            .net_in_full(net_in_full[r])
        );
    end
endmodule

// File: tb/strm_ep_tb.sv
`timescale 1ns/1ps
module strm_ep_tb;
    localparam int W = 32, DW = 4, AW = 3, SLACK = 2, TXN = 2, RXN = 2;
    localparam int DEPTH = 1 << AW;

    logic mclk = 0, nclk = 0, mrst = 1, nrst = 1;
    logic [TXN-1:0]          tx_req = '0, tx_valid = '0, tx_ready;
    logic [TXN-1:0][DW-1:0]  tx_dest = '0;
    logic [TXN-1:0][W-1:0]   tx_data = '0;
    logic [TXN-1:0][1:0]     tx_status;
    logic [RXN-1:0]          rx_valid, rx_ready = '0;
    logic [RXN-1:0][W-1:0]   rx_data;
    logic [TXN-1:0]          net_req, net_grant = '0, net_deny = '0, net_out_valid, net_out_full = '0;
    logic [TXN-1:0][DW-1:0]  net_dest;
    logic [TXN-1:0][W-1:0]   net_out_data;
    logic [RXN-1:0]          net_in_valid = '0, net_in_full;
    logic [RXN-1:0][W-1:0]   net_in_data = '0;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [W-1:0] txq0[$], txq1[$], rxq0[$], rxq1[$];
    logic [TXN-1:0] prev_req = '0;

    always #2.5 nclk = ~nclk;
    always #3.5 mclk = ~mclk;

    strm_ep #(.W(W), .DEST_W(DW), .FIFO_AW(AW), .SLACK(SLACK), .TX_PORTS(TXN), .RX_PORTS(RXN)) u_dut (
        .mclk(mclk), .mrst(mrst), .nclk(nclk), .nrst(nrst),
        .tx_req(tx_req), .tx_dest(tx_dest), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_status(tx_status),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .net_req(net_req), .net_dest(net_dest), .net_grant(net_grant), .net_deny(net_deny),
        .net_out_valid(net_out_valid), .net_out_data(net_out_data), .net_out_full(net_out_full),
        .net_in_valid(net_in_valid), .net_in_data(net_in_data), .net_in_full(net_in_full)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model of the outgoing streams, compared on every network cycle
    always @(negedge nclk) begin
        if (!nrst && !done) begin
            for (int i = 0; i < TXN; i++) begin
                if (net_out_valid[i]) begin
                    logic [W-1:0] e;
                    if (net_out_full[i]) chk(0, "R5 word sent while full", 1, 0);
                    if (!net_req[i]) chk(0, "R4 word sent without channel", 0, 1);
                    if (i == 0) begin
                        if (txq0.size() == 0) chk(0, "R4 unexpected word lane0", net_out_data[i], 0);
                        else begin e = txq0.pop_front(); chk(net_out_data[i] == e, "R4 order lane0", net_out_data[i], e); end
                    end else begin
                        if (txq1.size() == 0) chk(0, "R4 unexpected word lane1", net_out_data[i], 0);
                        else begin e = txq1.pop_front(); chk(net_out_data[i] == e, "R10 order lane1", net_out_data[i], e); end
                    end
                end
                if (prev_req[i] && !net_req[i]) begin
                    int pend;
                    pend = (i == 0) ? txq0.size() : txq1.size();
                    if (pend != 0 && tx_status[i] == 2'd1)
                        chk(0, "R6 released with words pending", pend, 0);
                end
                prev_req[i] = net_req[i];
            end
        end
    end

    task automatic push_tx(input int l, input logic [W-1:0] d);
        int k;
        k = 0;
        @(negedge mclk);
        while (!tx_ready[l] && k < 50) begin @(negedge mclk); k++; end
        tx_valid[l] = 1'b1; tx_data[l] = d;
        if (l == 0) txq0.push_back(d); else txq1.push_back(d);
        @(negedge mclk);
        tx_valid[l] = 1'b0;
    endtask

    task automatic wait_req(input int l, input bit lvl, input string tag);
        int k;
        k = 0;
        @(negedge nclk);
        while (net_req[l] != lvl && k < 30) begin @(negedge nclk); k++; end
        chk(net_req[l] == lvl, tag, net_req[l], lvl);
    endtask

    task automatic pulse_net(input int l, input bit is_grant);
        @(posedge nclk); #1;
        if (is_grant) net_grant[l] = 1'b1; else net_deny[l] = 1'b1;
        @(posedge nclk); #1;
        net_grant[l] = 1'b0; net_deny[l] = 1'b0;
    endtask

    task automatic set_full(input int l, input bit v);
        @(posedge nclk); #1;
        net_out_full[l] = v;
    endtask

    task automatic drain_rx(input int l, input int cycles, output int got);
        got = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge mclk);
            if (rx_valid[l]) begin
                logic [W-1:0] e;
                e = (l == 0) ? rxq0.pop_front() : rxq1.pop_front();
                chk(rx_data[l] == e, "R7 receive order", rx_data[l], e);
                rx_ready[l] = 1'b1;
                got++;
            end else rx_ready[l] = 1'b0;
            if ((l == 0 ? rxq0.size() : rxq1.size()) == 0 && rx_valid[l] == 1'b0) rx_ready[l] = 1'b0;
        end
        @(negedge mclk);
        rx_ready[l] = 1'b0;
    endtask

    initial begin
        int cnt;
        repeat (6) @(negedge nclk);
        nrst = 0;
        @(negedge mclk);
        mrst = 0;
        repeat (4) @(negedge mclk);

        // R1 reset state
        chk(net_req == '0, "R1 net_req", net_req, 0);
        chk(net_out_valid == '0, "R1 net_out_valid", net_out_valid, 0);
        chk(net_in_full == '0, "R1 net_in_full", net_in_full, 0);
        chk(rx_valid == '0, "R1 rx_valid", rx_valid, 0);
        chk(tx_ready == '1, "R1 tx_ready", tx_ready, 3);
        chk(tx_status == '0, "R1 tx_status", tx_status, 0);

        // R2/R4: buffer, request, grant, stream
        for (int k = 0; k < 3; k++) push_tx(0, 32'hA000_0000 + k);
        repeat (10) @(negedge nclk);
        chk(net_out_valid[0] == 1'b0, "R4 no word before request", net_out_valid[0], 0);
        @(negedge mclk); tx_dest[0] = 4'hA; tx_req[0] = 1'b1;
        wait_req(0, 1'b1, "R2 net_req rises");
        chk(net_dest[0] == 4'hA, "R2 net_dest", net_dest[0], 4'hA);
        chk(net_out_valid[0] == 1'b0, "R4 no word before grant", net_out_valid[0], 0);
        pulse_net(0, 1'b1);
        @(negedge nclk);
        chk(net_out_valid[0] == 1'b1, "R4 first word after grant", net_out_valid[0], 1);
        repeat (20) @(negedge nclk);
        chk(txq0.size() == 0, "R4 all words sent", txq0.size(), 0);
        repeat (10) @(negedge mclk);
        chk(tx_status[0] == 2'd1, "R2 status grant", tx_status[0], 1);

        // R5 backpressure
        set_full(0, 1'b1);
        for (int k = 0; k < 4; k++) push_tx(0, 32'hB000_0000 + k);
        repeat (20) @(negedge nclk);
        chk(txq0.size() == 4, "R5 held while full", txq0.size(), 4);
        set_full(0, 1'b0);
        repeat (20) @(negedge nclk);
        chk(txq0.size() == 0, "R5 resumed after full", txq0.size(), 0);

        // R6 release waits for drain
        set_full(0, 1'b1);
        for (int k = 0; k < 3; k++) push_tx(0, 32'hC000_0000 + k);
        repeat (6) @(negedge mclk);
        tx_req[0] = 1'b0;
        repeat (20) @(negedge nclk);
        chk(net_req[0] == 1'b1, "R6 held while words buffered", net_req[0], 1);
        set_full(0, 1'b0);
        repeat (20) @(negedge nclk);
        chk(net_req[0] == 1'b0, "R6 released after drain", net_req[0], 0);
        chk(txq0.size() == 0, "R6 nothing lost", txq0.size(), 0);

        // R3 deny with retry, then give up
        @(negedge mclk); tx_dest[0] = 4'h5; tx_req[0] = 1'b1;
        wait_req(0, 1'b1, "R3 request for deny");
        pulse_net(0, 1'b0);
        @(negedge nclk);
        chk(net_req[0] == 1'b0, "R3 drop after deny", net_req[0], 0);
        @(negedge nclk);
        chk(net_req[0] == 1'b1, "R3 retry while held", net_req[0], 1);
        repeat (10) @(negedge mclk);
        chk(tx_status[0] == 2'd2, "R3 status deny", tx_status[0], 2);
        @(negedge nclk);
        pulse_net(0, 1'b0);
        @(negedge mclk); tx_req[0] = 1'b0;
        repeat (20) @(negedge nclk);
        chk(net_req[0] == 1'b0, "R3 stays low after giving up", net_req[0], 0);

        // R2 withdrawal before an answer
        @(negedge mclk); tx_req[0] = 1'b1;
        wait_req(0, 1'b1, "R2 second request");
        @(negedge mclk); tx_req[0] = 1'b0;
        wait_req(0, 1'b0, "R2 withdrawn request");
        repeat (10) @(negedge mclk);
        chk(tx_status[0] == 2'd0, "R2 status idle after withdraw", tx_status[0], 0);

        // R9 transmit buffer depth, lane 1 unrequested
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge mclk);
            if (tx_ready[1]) begin
                tx_valid[1] = 1'b1; tx_data[1] = 32'hD000_0000 + k;
                txq1.push_back(32'hD000_0000 + k); cnt++;
            end else tx_valid[1] = 1'b0;
        end
        @(negedge mclk); tx_valid[1] = 1'b0;
        chk(cnt == DEPTH, "R9 words accepted", cnt, DEPTH);
        chk(tx_ready[1] == 1'b0, "R9 tx_ready low", tx_ready[1], 0);
        chk(tx_ready[0] == 1'b1, "R10 lane0 ready unaffected", tx_ready[0], 1);
        tx_dest[1] = 4'h3; tx_req[1] = 1'b1;
        wait_req(1, 1'b1, "R10 lane1 request");
        chk(net_dest[1] == 4'h3, "R10 lane1 dest", net_dest[1], 3);
        pulse_net(1, 1'b1);
        repeat (30) @(negedge nclk);
        chk(txq1.size() == 0, "R10 lane1 streamed", txq1.size(), 0);
        repeat (10) @(negedge mclk);
        chk(tx_status[1] == 2'd1, "R10 lane1 grant", tx_status[1], 1);
        chk(tx_status[0] == 2'd0, "R10 lane0 status kept", tx_status[0], 0);

        // R8/R7 receive fill
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge nclk); #1;
            if (!net_in_full[0]) begin
                net_in_valid[0] = 1'b1; net_in_data[0] = 32'hE000_0000 + k;
                rxq0.push_back(32'hE000_0000 + k); cnt++;
            end else net_in_valid[0] = 1'b0;
        end
        @(posedge nclk); #1; net_in_valid[0] = 1'b0;
        chk(cnt == DEPTH - SLACK, "R8 accepted before full", cnt, DEPTH - SLACK);
        @(negedge nclk);
        chk(net_in_full[0] == 1'b1, "R8 full raised", net_in_full[0], 1);
        chk(net_in_full[1] == 1'b0, "R10 lane1 not full", net_in_full[1], 0);
        for (int k = 0; k < 3; k++) begin
            @(posedge nclk); #1;
            net_in_valid[1] = 1'b1; net_in_data[1] = 32'hF000_0000 + k;
            rxq1.push_back(32'hF000_0000 + k);
        end
        @(posedge nclk); #1; net_in_valid[1] = 1'b0;
        drain_rx(0, 30, cnt);
        chk(cnt == DEPTH - SLACK, "R7 words delivered", cnt, DEPTH - SLACK);
        repeat (10) @(negedge nclk);
        chk(net_in_full[0] == 1'b0, "R8 full cleared", net_in_full[0], 0);
        drain_rx(1, 20, cnt);
        chk(cnt == 3, "R10 lane1 words delivered", cnt, 3);
        @(negedge mclk);
        chk(rx_valid == '0, "R7 receive empty", rx_valid, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge nclk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule